// File: doc/BRIEF.md
# Exception Entry Register Update Unit

This block performs the state changes a processor core makes when it takes an exception. The core's exception logic presents a request carrying a class code, a sub-cause code, the address of the instruction being interrupted, the current machine state word, the faulting data address and a store flag. The unit captures the request, decodes it, and one cycle later writes all of the saved-state registers, the new machine state word and the redirect program counter together. It marks that cycle with a single-cycle `taken_o` pulse.

The saved-state word keeps the low half of the old machine state and ORs the class-specific cause bits into its upper half. Data-side faults also load the fault address and status registers. The new machine state clears a fixed group of enable bits. The redirect target is a vector offset that depends on the class, added to a base chosen by the interrupt-prefix bit. If an exception is taken while the old state marks the machine as non-recoverable, the unit raises a fatal double-fault pulse in the same cycle as `taken_o`.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted and after it is released, every register output is zero and `busy_o`, `taken_o` and `double_fault_o` are low.
- R2: A request is accepted on a clock edge where `req_i` is high, `busy_o` is low and `cause_i` is 0 to 9. `busy_o` is then high for exactly one cycle. `taken_o` is high for exactly the following cycle, and the register outputs change only in that cycle. A request presented while `busy_o` is high, or during the `taken_o` cycle, is accepted only on a later edge.
- R3: `msr_o` equals the old state word with bits 18, 15, 13, 11, 10, 9, 8, 5 and 1 forced to zero and every other bit kept.
- R4: `pc_o` is the vector base plus the class offset. The base is 0xFFF00000 when bit 6 of the new state word is set and 0x00000000 otherwise.
- R5: The class offsets, by `cause_i` code, are: 0 machine check 0x200, 1 data storage 0x300, 2 instruction storage 0x400, 3 external 0x500, 4 alignment 0x600, 5 program 0x700, 6 FP unavailable 0x800, 7 decrementer 0x900, 8 system call 0xC00, 9 FP assist 0xE00.
- R6: `srr0_o` receives `cia_i`, or `cia_i` + 4 for the system call class.
- R7: `srr1_o[15:0]` equals the old state word's bits [15:0]. `srr1_o[31:16]` holds only cause bits. For instruction storage (code 2), `sub_i` selects the bit: 0 direct-store error sets bit 28, 1 table miss sets bit 30, 2 protection sets bit 27, 4 segment-table miss sets bit 21.
- R8: For program (code 5), `sub_i` selects the bit: 0 FP enabled sets bit 20, 1 illegal sets bit 19, 2 privileged sets bit 18, 3 trap sets bit 17, 4 unsupported optional instruction sets bit 19. All other classes add no cause bits.
- R9: For data storage (code 1), `dar_o` gets `addr_i`. `dsisr_o` gets one bit chosen by `sub_i` (0 direct-store 31, 1 table miss 30, 2 protection 27, 3 external-access violation 20, 4 segment-table miss 21, 5 external access disabled 22), ORed with bit 25 when `store_i` is high.
- R10: For alignment (code 4), `dar_o` gets `addr_i` and `dsisr_o` becomes zero.
- R11: Every class other than data storage and alignment leaves `dar_o` and `dsisr_o` unchanged.
- R12: `double_fault_o` is high for exactly the `taken_o` cycle of an exception whose old state word had bit 1 clear, and is low otherwise.
- R13: A request with `cause_i` from 10 to 15 is ignored. `busy_o` and `taken_o` stay low and no register output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request |
| cause_i | input | 4 | Exception class code |
| sub_i | input | 3 | Sub-cause for storage and program classes |
| cia_i | input | 32 | Address of the excepting instruction |
| msr_i | input | 32 | Current machine state word |
| addr_i | input | 32 | Faulting data address |
| store_i | input | 1 | Faulting access was a store |
| busy_o | output | 1 | Request captured, update pending |
| taken_o | output | 1 | One-cycle pulse: registers updated this cycle |
| double_fault_o | output | 1 | Exception taken while non-recoverable |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state and cause bits |
| dar_o | output | 32 | Fault data address |
| dsisr_o | output | 32 | Data fault status |
| msr_o | output | 32 | New machine state word |
| pc_o | output | 32 | Redirect program counter |

## Verification
Two events can land in the same cycle. The first is the fatal double-fault flag, which shares its cycle with the normal register update: the bench clears bit 1 in the presented state word and expects both pulses together, with the update still done in full. The second is a new request held high through the `taken_o` cycle of the previous one. The bench issues requests back to back, and the reference model must see the second capture happen only on the edge after the pulse, with no overlap of `busy_o` and `taken_o`.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int SAVE_W = 16;
  localparam int NUM_CAUSE = 10;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    EXC_MCHK = 4'd0, EXC_DSI = 4'd1, EXC_ISI = 4'd2, EXC_EXT = 4'd3,
    EXC_ALIGN = 4'd4, EXC_PROG = 4'd5, EXC_FPU = 4'd6, EXC_DEC = 4'd7,
    EXC_SC = 4'd8, EXC_FPA = 4'd9
  } exc_cause_e;

  // state word bits
  localparam int MSR_IP = 6;
  localparam int MSR_RI = 1;
  localparam int N_CLR  = 9;
  localparam int CLR_POS [N_CLR] = '{18, 15, 13, 11, 10, 9, 8, 5, 1};

  // saved-state cause bits
  localparam int S1_TBL = 30, S1_DST = 28, S1_PROT = 27, S1_SEG = 21;
  localparam int S1_FPEN = 20, S1_ILL = 19, S1_PRIV = 18, S1_TRAP = 17;

  // data fault status bits
  localparam int DS_DST = 31, DS_TBL = 30, DS_PROT = 27, DS_STORE = 25;
  localparam int DS_XDIS = 22, DS_SEG = 21, DS_XVIO = 20;

  typedef struct packed {
    logic [11:0] offset;
    word_t       srr1_set;
    word_t       dsisr;
    logic        wr_dar;
    logic        is_sc;
  } exc_dec_t;

  function automatic word_t bit_at(int pos);
    return word_t'(1) << pos;
  endfunction
endpackage

// File: rtl/exc_cause_dec.sv
module exc_cause_dec
  import exc_pkg::*;
(
  input  logic [3:0] cause_i,
  input  logic [2:0] sub_i,
  input  logic       store_i,
  output exc_dec_t   dec_o
);
  exc_cause_e cause;
  word_t      isi_bits, prog_bits, dsi_bits;

  assign cause = exc_cause_e'(cause_i);

  always_comb begin
    unique case (sub_i)
      3'd0:    isi_bits = bit_at(S1_DST);
      3'd1:    isi_bits = bit_at(S1_TBL);
      3'd2:    isi_bits = bit_at(S1_PROT);
      3'd4:    isi_bits = bit_at(S1_SEG);
      default: isi_bits = '0;
    endcase
    unique case (sub_i)
      3'd0:       prog_bits = bit_at(S1_FPEN);
      3'd1, 3'd4: prog_bits = bit_at(S1_ILL);
      3'd2:       prog_bits = bit_at(S1_PRIV);
      3'd3:       prog_bits = bit_at(S1_TRAP);
      default:    prog_bits = '0;
    endcase
    unique case (sub_i)
      3'd0:    dsi_bits = bit_at(DS_DST);
      3'd1:    dsi_bits = bit_at(DS_TBL);
      3'd2:    dsi_bits = bit_at(DS_PROT);
      3'd3:    dsi_bits = bit_at(DS_XVIO);
      3'd4:    dsi_bits = bit_at(DS_SEG);
      3'd5:    dsi_bits = bit_at(DS_XDIS);
      default: dsi_bits = '0;
    endcase
  end

  always_comb begin
    dec_o = '0;
    unique case (cause)
      EXC_MCHK:  dec_o.offset = 12'h200;
      EXC_DSI: begin
        dec_o.offset = 12'h300;
        dec_o.wr_dar = 1'b1;
        dec_o.dsisr  = dsi_bits | (store_i ? bit_at(DS_STORE) : '0);
      end
      EXC_ISI: begin
        dec_o.offset   = 12'h400;
        dec_o.srr1_set = isi_bits;
      end
      EXC_EXT:   dec_o.offset = 12'h500;
      EXC_ALIGN: begin
        dec_o.offset = 12'h600;
        dec_o.wr_dar = 1'b1;
      end
      EXC_PROG: begin
        dec_o.offset   = 12'h700;
        dec_o.srr1_set = prog_bits;
      end
      EXC_FPU:   dec_o.offset = 12'h800;
      EXC_DEC:   dec_o.offset = 12'h900;
      EXC_SC: begin
        dec_o.offset = 12'hC00;
        dec_o.is_sc  = 1'b1;
      end
      EXC_FPA:   dec_o.offset = 12'hE00;
      default:   dec_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_msr_xform.sv
module exc_msr_xform
  import exc_pkg::*;
(
  input  word_t msr_i,
  output word_t new_msr_o,
  output word_t saved_o,
  output logic  ri_ok_o
);
  word_t keep_mask;

  always_comb begin
    keep_mask = '1;
    for (int i = 0; i < N_CLR; i++) keep_mask[CLR_POS[i]] = 1'b0;
  end

  assign new_msr_o = msr_i & keep_mask;
  assign saved_o   = {{(XLEN-SAVE_W){1'b0}}, msr_i[SAVE_W-1:0]};
  assign ri_ok_o   = msr_i[MSR_RI];
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter word_t VEC_HI = 32'hFFF0_0000
) (
  input  word_t       new_msr_i,
  input  logic [11:0] offset_i,
  output word_t       pc_o
);
  word_t base;
  assign base = new_msr_i[MSR_IP] ? VEC_HI : '0;
  assign pc_o = base + word_t'(offset_i);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_HI  = 32'hFFF0_0000,
  parameter int          SC_STEP = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [3:0]  cause_i,
  input  logic [2:0]  sub_i,
  input  logic [31:0] cia_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] addr_i,
  input  logic        store_i,
  output logic        busy_o,
  output logic        taken_o,
  output logic        double_fault_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] dar_o,
  output logic [31:0] dsisr_o,
  output logic [31:0] msr_o,
  output logic [31:0] pc_o
);
  logic       pend_q, taken_q, df_q;
  logic [3:0] cause_q;
  logic [2:0] sub_q;
  logic       store_q;
  word_t      cia_q, msr_q, addr_q;
  word_t      srr0_q, srr1_q, dar_q, dsisr_q, nmsr_q, pc_q;

  exc_dec_t dec;
  word_t    new_msr, saved, vec_pc;
  logic     ri_ok, accept;

  assign accept = req_i & ~pend_q & (int'(cause_i) < NUM_CAUSE);

  exc_cause_dec u_dec (
    .cause_i (cause_q),
    .sub_i   (sub_q),
    .store_i (store_q),
    .dec_o   (dec)
  );

  exc_msr_xform u_msr (
    .msr_i     (msr_q),
    .new_msr_o (new_msr),
    .saved_o   (saved),
    .ri_ok_o   (ri_ok)
  );

  exc_vec_gen #(.VEC_HI(VEC_HI)) u_vec (
    .new_msr_i (new_msr),
    .offset_i  (dec.offset),
    .pc_o      (vec_pc)
  );

  // capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      cause_q <= '0;
      sub_q   <= '0;
      store_q <= 1'b0;
      cia_q   <= '0;
      msr_q   <= '0;
      addr_q  <= '0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        cause_q <= cause_i;
        sub_q   <= sub_i;
        store_q <= store_i;
        cia_q   <= cia_i;
        msr_q   <= msr_i;
        addr_q  <= addr_i;
      end
    end
  end

  // commit stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      df_q    <= 1'b0;
      srr0_q  <= '0;
      srr1_q  <= '0;
      dar_q   <= '0;
      dsisr_q <= '0;
      nmsr_q  <= '0;
      pc_q    <= '0;
    end else begin
      taken_q <= pend_q;
      df_q    <= pend_q & ~ri_ok;
      if (pend_q) begin
        srr0_q <= dec.is_sc ? cia_q + word_t'(SC_STEP) : cia_q;
        srr1_q <= saved | dec.srr1_set;
        nmsr_q <= new_msr;
        pc_q   <= vec_pc;
        if (dec.wr_dar) begin
          dar_q   <= addr_q;
          dsisr_q <= dec.dsisr;
        end
      end
    end
  end

  assign busy_o         = pend_q;
  assign taken_o        = taken_q;
  assign double_fault_o = df_q;
  assign srr0_o         = srr0_q;
  assign srr1_o         = srr1_q;
  assign dar_o          = dar_q;
  assign dsisr_o        = dsisr_q;
  assign msr_o          = nmsr_q;
  assign pc_o           = pc_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        taken_o,
  input logic        double_fault_o,
  input logic [31:0] srr0_o,
  input logic [31:0] msr_o,
  input logic [31:0] pc_o
);
  localparam logic [31:0] CLR_BITS = 32'h0004_AF22;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R2
  AST_TAKEN_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(busy_o)); // R2
  AST_TAKEN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> !taken_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> ($stable(srr0_o) && $stable(pc_o) && $stable(msr_o))); // R2
  AST_MSR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> ((msr_o & CLR_BITS) == 32'h0)); // R3
  AST_VEC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && msr_o[6]) |-> (pc_o[31:20] == 12'hFFF)); // R4
  AST_VEC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !msr_o[6]) |-> (pc_o[31:12] == 20'h0)); // R4
  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (pc_o[7:0] == 8'h0 && pc_o[11:8] >= 4'h2)); // R5
  AST_DFAULT_WITH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    double_fault_o |-> taken_o); // R12
endmodule

bind exc_entry_unit exc_entry_chk u_exc_entry_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .taken_o        (taken_o),
  .double_fault_o (double_fault_o),
  .srr0_o         (srr0_o),
  .msr_o          (msr_o),
  .pc_o           (pc_o)
);

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  cause = '0;
  logic [2:0]  sub = '0;
  logic [31:0] cia = '0, msr = '0, addr = '0;
  logic        store = 1'b0;
  logic        busy, taken, dfault;
  logic [31:0] srr0, srr1, dar, dsisr, nmsr, pc;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  exc_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .cause_i(cause), .sub_i(sub),
    .cia_i(cia), .msr_i(msr), .addr_i(addr), .store_i(store),
    .busy_o(busy), .taken_o(taken), .double_fault_o(dfault),
    .srr0_o(srr0), .srr1_o(srr1), .dar_o(dar), .dsisr_o(dsisr),
    .msr_o(nmsr), .pc_o(pc)
  );

  // reference model
  localparam logic [31:0] M_CLR = (32'd1 << 18) | (32'd1 << 15) | (32'd1 << 13) |
    (32'd1 << 11) | (32'd1 << 10) | (32'd1 << 9) | (32'd1 << 8) | (32'd1 << 5) | (32'd1 << 1);

  function automatic logic [31:0] m_off(int c);
    case (c)
      0: return 32'h200; 1: return 32'h300; 2: return 32'h400; 3: return 32'h500;
      4: return 32'h600; 5: return 32'h700; 6: return 32'h800; 7: return 32'h900;
      8: return 32'hC00; 9: return 32'hE00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_cause_bits(int c, int s);
    if (c == 2) begin
      case (s)
        0: return 32'd1 << 28; 1: return 32'd1 << 30;
        2: return 32'd1 << 27; 4: return 32'd1 << 21;
        default: return 32'h0;
      endcase
    end
    if (c == 5) begin
      case (s)
        0: return 32'd1 << 20; 1, 4: return 32'd1 << 19;
        2: return 32'd1 << 18; 3: return 32'd1 << 17;
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_dsisr(int s, logic st);
    logic [31:0] v;
    case (s)
      0: v = 32'd1 << 31; 1: v = 32'd1 << 30; 2: v = 32'd1 << 27;
      3: v = 32'd1 << 20; 4: v = 32'd1 << 21; 5: v = 32'd1 << 22;
      default: v = 32'h0;
    endcase
    return st ? (v | (32'd1 << 25)) : v;
  endfunction

  logic        e_busy, e_taken, e_df;
  logic [31:0] e_srr0, e_srr1, e_dar, e_dsisr, e_msr, e_pc;
  int          k_c, k_s;
  logic        k_st;
  logic [31:0] k_cia, k_msr, k_addr;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_busy = 0; e_taken = 0; e_df = 0;
      e_srr0 = 0; e_srr1 = 0; e_dar = 0; e_dsisr = 0; e_msr = 0; e_pc = 0;
    end else begin
      e_taken = 0; e_df = 0;
      if (e_busy) begin
        e_taken = 1;
        e_df    = !k_msr[1];
        e_srr0  = (k_c == 8) ? k_cia + 32'd4 : k_cia;
        e_srr1  = (k_msr & 32'h0000_FFFF) | m_cause_bits(k_c, k_s);
        e_msr   = k_msr & ~M_CLR;
        e_pc    = (e_msr[6] ? 32'hFFF0_0000 : 32'h0) + m_off(k_c);
        if (k_c == 1) begin e_dar = k_addr; e_dsisr = m_dsisr(k_s, k_st); end
        if (k_c == 4) begin e_dar = k_addr; e_dsisr = 32'h0; end
        e_busy = 0;
      end else if (req && int'(cause) <= 9) begin
        k_c = int'(cause); k_s = int'(sub); k_st = store;
        k_cia = cia; k_msr = msr; k_addr = addr;
        e_busy = 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2 busy", 32'(busy), 32'(e_busy));
      chk("R2 taken", 32'(taken), 32'(e_taken));
      chk("R12 double fault", 32'(dfault), 32'(e_df));
      chk("R3 msr", nmsr, e_msr);
      chk("R4 R5 pc", pc, e_pc);
      chk("R6 srr0", srr0, e_srr0);
      chk("R7 R8 srr1", srr1, e_srr1);
      chk("R9 R10 R11 dar", dar, e_dar);
      chk("R9 R10 R11 dsisr", dsisr, e_dsisr);
    end
  end

  task automatic issue(int c, int s, logic [31:0] a_cia, logic [31:0] a_msr,
                       logic [31:0] a_addr, logic st);
    @(negedge clk);
    req = 1; cause = 4'(c); sub = 3'(s);
    cia = a_cia; msr = a_msr; addr = a_addr; store = st;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      if (e_busy) break;
    end
    req = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held_dar, held_pc;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 reset srr0", srr0, 32'h0);
    chk("R1 reset pc", pc, 32'h0);
    chk("R1 reset flags", {29'h0, busy, taken, dfault}, 32'h0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 after release msr", nmsr, 32'h0);

    // every class, prefix set and clear
    for (int c = 0; c <= 9; c++) begin
      issue(c, 0, 32'h0000_1000 + 32'(c * 16), 32'hFFFF_FFFF, 32'hA000_0000 + 32'(c), 1'b0);
      issue(c, 1, 32'h0040_2000 + 32'(c * 4), 32'h0004_A7B2, 32'hB000_0000 + 32'(c), 1'b1);
    end
    settle();

    // data storage sub-causes, both directions
    for (int s = 0; s <= 5; s++) begin
      issue(1, s, 32'h0000_3000, 32'h0000_8002, 32'hDEAD_0000 + 32'(s), 1'b0);
      issue(1, s, 32'h0000_3004, 32'h0000_8042, 32'hBEEF_0000 + 32'(s), 1'b1);
    end
    // instruction storage and program sub-causes
    for (int s = 0; s <= 7; s++) begin
      issue(2, s, 32'h0000_4000 + 32'(s), 32'h1234_FFFF, 32'h0, 1'b0);
      issue(5, s, 32'h0000_5000 + 32'(s), 32'h0000_00C2, 32'h0, 1'b0);
    end
    settle();

    // R8: optional instruction reports the illegal bit
    issue(5, 4, 32'h0000_7000, 32'h0000_0002, 32'h0, 1'b0);
    settle();
    chk("R8 optional -> illegal", {16'h0, srr1[31:16]}, 32'h0000_0008);

    // R10: alignment
    issue(4, 0, 32'h0000_6000, 32'h0000_0002, 32'h1357_9BDF, 1'b1);
    settle();
    chk("R10 align dar", dar, 32'h1357_9BDF);
    chk("R10 align dsisr", dsisr, 32'h0);

    // R11: non-data class leaves dar/dsisr
    issue(1, 2, 32'h0000_6100, 32'h0000_0002, 32'h2468_ACE0, 1'b1);
    settle();
    held_dar = dar;
    issue(3, 0, 32'h0000_6200, 32'h0000_0002, 32'h1111_1111, 1'b0);
    issue(8, 0, 32'h0000_6300, 32'h0000_0002, 32'h2222_2222, 1'b1);
    settle();
    chk("R11 dar held", dar, held_dar);
    chk("R11 dsisr held", dsisr, 32'h0A00_0000);
    chk("R6 syscall srr0", srr0, 32'h0000_6304);

    // R12: double fault with bit 1 clear
    issue(7, 0, 32'h0000_9000, 32'hFFFF_FFFD, 32'h0, 1'b0);
    settle();
    issue(0, 0, 32'h0000_9100, 32'h0000_0000, 32'h0, 1'b0);
    settle();

    // R13: invalid class codes are ignored
    held_pc = pc;
    for (int c = 10; c <= 15; c++) begin
      @(negedge clk);
      req = 1; cause = 4'(c); cia = 32'hCAFE_0000; msr = 32'h0; addr = 32'h0;
      @(negedge clk);
      chk("R13 invalid busy", 32'(busy), 32'h0);
    end
    req = 0;
    settle();
    chk("R13 invalid pc held", pc, held_pc);
    chk("R13 invalid taken", 32'(taken), 32'h0);

    settle();
    finish_run();
  end
endmodule